// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It takes words from an external transmit FIFO, shifts them out on `mosi` with a generated serial clock, and assembles the bits that come back on `miso` into words that it hands to an external receive FIFO. The serial clock rate, the word length (2 to 8, 16 or 32 bits), the clock polarity, the phase, the bit order and an internal loopback path are held in a configuration bank. That bank only accepts writes while the engine is disabled and not in the middle of a word.

Control is a small state machine with three states. `ST_IDLE` waits for work. It leaves for `ST_SHIFT` (transition *start*) when the engine is enabled, at least one direction is on, and the transmit FIFO is not empty. On that transition it pops one word. `ST_SHIFT` runs the baud counter and toggles the serial clock once per half period. After the trailing edge of the last bit it moves to `ST_FINISH` (transition *last edge*). `ST_FINISH` delivers the received word and always returns to `ST_IDLE` (transition *retire*). A transmit interrupt pulse marks the moment the FIFO has been drained, and a busy flag covers the whole time that words remain, including the last word still on the wire.

A word is always started by a transmit FIFO entry. With the transmitter off, the entry only acts as a frame token and its data is not sent.

Top module: `spi_shift_engine`

## Requirements
- R1: While a word shifts, each half period of `sclk` lasts `cfg_brt`+1 clock cycles, so one full `sclk` period is 2×(`cfg_brt`+1) cycles; `cfg_brt`=0 is the fastest rate.
- R2: `cfg_wlen_m1` holds the word length minus one. A write is accepted only for the values 1..7, 15 and 31 (2–8, 16, 32 bits). A write with any other value keeps the previous length while the other fields still update.
- R3: Between words, `sclk` rests at `cfg_sclk_hi`, and so does `mosi` (the idle line level).
- R4: With `cfg_lead_smp`=1, the first bit is on `mosi` before the first edge, `miso` is sampled on leading edges, and `mosi` changes on trailing edges. With `cfg_lead_smp`=0, `mosi` changes on leading edges and `miso` is sampled on trailing edges. A leading edge is the `sclk` transition away from its rest level.
- R5: `cfg_msb_first`=1 sends and receives the highest bit of the word first. With 0, bit 0 goes first. Received words are right-aligned with zeros above the word length.
- R6: With `cfg_loopback`=1, the receive path takes the engine's own `mosi` and ignores the `miso` pin.
- R7: Configuration writes are ignored while `en`=1 or while a word is in flight.
- R8: With `tx_off`=1, each popped word is still clocked out, but `mosi` holds the idle level (`cfg_sclk_hi`) for every bit.
- R9: With `rx_off`=1, received words are discarded and `rxf_push` stays low.
- R10: With `tx_off` and `rx_off` both set, the engine pops nothing, raises no clock and reports not busy.
- R11: `tx_irq` pulses for one cycle in the cycle after a pop that leaves the transmit FIFO empty.
- R12: `busy` is high from the start of a word while words remain, and stays high after the FIFO empties until the last word has fully shifted.
- R13: Exactly one `rxf_push` occurs per word shifted while the receiver is on.
- R14: After reset the outputs are idle (`sclk`=0, `mosi`=0, `busy`=0, no pop, no push, no interrupt) and the configuration is 8-bit words, `cfg_brt`=0, rest level low, leading-edge sampling, MSB first, no loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable; 0 = configuration mode |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_brt | input | 16 | Baud reload value |
| cfg_wlen_m1 | input | 5 | Word length minus one |
| cfg_sclk_hi | input | 1 | Clock rest level and idle data level |
| cfg_lead_smp | input | 1 | 1 = sample on leading edge, 0 = sample on trailing edge |
| cfg_msb_first | input | 1 | 1 = MSB first, 0 = LSB first |
| cfg_loopback | input | 1 | Route `mosi` to the receive path |
| tx_off | input | 1 | Transmitter off |
| rx_off | input | 1 | Receiver off |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_data | input | 32 | Transmit FIFO head word |
| txf_pop | output | 1 | Pop the transmit FIFO head |
| rxf_push | output | 1 | Push `rxf_data` to the receive FIFO |
| rxf_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Words pending or shifting |
| tx_irq | output | 1 | Transmit FIFO drained pulse |

## Verification
The bench builds the engine with its default parameters: a 32-bit data path, a 16-bit baud reload and a 5-bit length field. These defaults cover every legal word length up to 32 bits, including the wide bit indices used for 16- and 32-bit words. Reload values are kept between 0 and 3 so that many configurations fit in a short run. This still separates the one-cycle half period at the fastest rate from the longer ones. A slave model in the bench drives `miso` and captures `mosi` according to the configured phase and bit order. This lets each random mode, length and loopback combination be checked in both directions.

// File: rtl/spi_se_pkg.sv
package spi_se_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } se_state_e;

    // Supported lengths minus one: 1..7, 15, 31 (bounded by the data path)
    function automatic logic wlen_legal(input logic [7:0] m1, input int unsigned dw);
        return (((m1 >= 8'd1) && (m1 <= 8'd7)) || (m1 == 8'd15) || (m1 == 8'd31))
               && (32'(m1) < dw);
    endfunction

endpackage

// File: rtl/spi_se_cfg.sv
module spi_se_cfg
    import spi_se_pkg::*;
#(
    parameter int DW  = 32,
    parameter int BRW = 16,
    parameter int LW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lock,
    input  logic           wr,
    input  logic [BRW-1:0] w_brt,
    input  logic [LW-1:0]  w_wlen_m1,
    input  logic           w_sclk_hi,
    input  logic           w_lead_smp,
    input  logic           w_msb_first,
    input  logic           w_loopback,
    output logic [BRW-1:0] brt,
    output logic [LW-1:0]  wlen_m1,
    output logic           sclk_hi,
    output logic           lead_smp,
    output logic           msb_first,
    output logic           loopback
);
    localparam logic [LW-1:0] DEF_WLEN = LW'(7);

    logic accept;
    assign accept = wr && !lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brt       <= '0;
            wlen_m1   <= DEF_WLEN;
            sclk_hi   <= 1'b0;
            lead_smp  <= 1'b1;
            msb_first <= 1'b1;
            loopback  <= 1'b0;
        end else if (accept) begin
            brt       <= w_brt;
            sclk_hi   <= w_sclk_hi;
            lead_smp  <= w_lead_smp;
            msb_first <= w_msb_first;
            loopback  <= w_loopback;
            if (wlen_legal(8'(w_wlen_m1), DW)) begin
                wlen_m1 <= w_wlen_m1;
            end
        end
    end

    // R7: fields hold while locked
    a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable({brt, wlen_m1, sclk_hi, lead_smp, msb_first, loopback}));

    // R2: stored length is always a supported one
    a_r2_legal_len: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> wlen_legal(8'(wlen_m1), DW));

endmodule

// File: rtl/spi_se_baud.sv
module spi_se_baud #(
    parameter int BRW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [BRW-1:0] reload,
    output logic           tick
);
    logic [BRW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || (cnt == '0)) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);

    // R1: no back-to-back ticks unless the reload is zero
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (reload != '0)) |=> !tick);

endmodule

// File: rtl/spi_se_shifter.sv
module spi_se_shifter #(
    parameter int DW = 32,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_word,
    input  logic          load_txoff,
    input  logic [LW-1:0] wlen_m1,
    input  logic          msb_first,
    input  logic          lead_smp,
    input  logic          idle_lvl,
    input  logic          lead,
    input  logic          trail,
    input  logic [LW-1:0] bit_k,
    input  logic          park,
    input  logic          sin,
    output logic          sout,
    output logic [DW-1:0] rx_word
);
    logic [DW-1:0] tx_w;
    logic [DW-1:0] rx_w;
    logic          mosi_q;
    logic          off_q;
    logic [LW-1:0] bit_k1;

    assign bit_k1 = bit_k + 1'b1;

    function automatic logic [LW-1:0] pos(input logic [LW-1:0] i);
        return msb_first ? (wlen_m1 - i) : i;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_w   <= '0;
            rx_w   <= '0;
            mosi_q <= 1'b0;
            off_q  <= 1'b0;
        end else if (load) begin
            tx_w   <= load_word;
            rx_w   <= '0;
            off_q  <= load_txoff;
            mosi_q <= (lead_smp && !load_txoff) ? load_word[pos('0)] : idle_lvl;
        end else if (park) begin
            mosi_q <= idle_lvl;
        end else begin
            if (lead_smp ? lead : trail) begin
                rx_w[pos(bit_k)] <= sin;
            end
            if (lead_smp && trail && (bit_k != wlen_m1)) begin
                mosi_q <= off_q ? idle_lvl : tx_w[pos(bit_k1)];
            end
            if (!lead_smp && lead) begin
                mosi_q <= off_q ? idle_lvl : tx_w[pos(bit_k)];
            end
        end
    end

    assign sout    = mosi_q;
    assign rx_word = rx_w;

    // R8: transmitter off keeps the data line at the idle level
    a_r8_txoff_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (off_q && !load) |=> (sout == $past(idle_lvl)));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_se_pkg::*;
#(
    parameter int DW  = 32,
    parameter int BRW = 16,
    parameter int LW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           cfg_wr,
    input  logic [BRW-1:0] cfg_brt,
    input  logic [LW-1:0]  cfg_wlen_m1,
    input  logic           cfg_sclk_hi,
    input  logic           cfg_lead_smp,
    input  logic           cfg_msb_first,
    input  logic           cfg_loopback,
    input  logic           tx_off,
    input  logic           rx_off,
    input  logic           txf_empty,
    input  logic [DW-1:0]  txf_data,
    output logic           txf_pop,
    output logic           rxf_push,
    output logic [DW-1:0]  rxf_data,
    output logic           sclk,
    output logic           mosi,
    input  logic           miso,
    output logic           busy,
    output logic           tx_irq
);
    localparam int HW = LW + 1;

    se_state_e      state, nxt;
    logic [BRW-1:0] brt_q;
    logic [LW-1:0]  wlen_q;
    logic           pol_q, lsmp_q, msb_q, loop_q;
    logic           tick, run, park, start, last;
    logic           lead, trail;
    logic [HW-1:0]  hcnt;
    logic [LW-1:0]  bit_k;
    logic           sclk_q, rxoff_q, popped_q;
    logic           sin;

    assign start = en && !(tx_off && rx_off) && !txf_empty;
    assign bit_k = hcnt[HW-1:1];
    assign lead  = tick && !hcnt[0];
    assign trail = tick && hcnt[0];
    assign last  = trail && (bit_k == wlen_q);
    assign sin   = loop_q ? mosi : miso;

    spi_se_cfg #(.DW(DW), .BRW(BRW), .LW(LW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .lock(en || (state != ST_IDLE)), .wr(cfg_wr),
        .w_brt(cfg_brt), .w_wlen_m1(cfg_wlen_m1), .w_sclk_hi(cfg_sclk_hi),
        .w_lead_smp(cfg_lead_smp), .w_msb_first(cfg_msb_first), .w_loopback(cfg_loopback),
        .brt(brt_q), .wlen_m1(wlen_q), .sclk_hi(pol_q),
        .lead_smp(lsmp_q), .msb_first(msb_q), .loopback(loop_q)
    );

    spi_se_baud #(.BRW(BRW)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .reload(brt_q), .tick(tick)
    );

    spi_se_shifter #(.DW(DW), .LW(LW)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(txf_pop), .load_word(txf_data), .load_txoff(tx_off),
        .wlen_m1(wlen_q), .msb_first(msb_q), .lead_smp(lsmp_q), .idle_lvl(pol_q),
        .lead(lead), .trail(trail), .bit_k(bit_k), .park(park),
        .sin(sin), .sout(mosi), .rx_word(rxf_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = start ? ST_SHIFT : ST_IDLE;
            ST_SHIFT:  nxt = last ? ST_FINISH : ST_SHIFT;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt     <= '0;
            sclk_q   <= 1'b0;
            rxoff_q  <= 1'b0;
            popped_q <= 1'b0;
        end else begin
            popped_q <= txf_pop;
            if (txf_pop) rxoff_q <= rx_off;
            if (state != ST_SHIFT) begin
                hcnt   <= '0;
                sclk_q <= pol_q;
            end else if (tick) begin
                hcnt   <= hcnt + 1'b1;
                sclk_q <= ~sclk_q;
            end
        end
    end

    // outputs
    always_comb begin
        txf_pop  = (state == ST_IDLE) && start;
        run      = (state == ST_SHIFT);
        park     = (state != ST_SHIFT);
        rxf_push = (state == ST_FINISH) && !rxoff_q;
        busy     = (state != ST_IDLE) || start;
        tx_irq   = popped_q && txf_empty;
    end

    assign sclk = sclk_q;

    // R3: clock back at rest level once the word is done
    a_r3_sclk_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH) |-> (sclk == pol_q));

    // R10: both directions off never pops
    a_r10_off_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_off && rx_off) |-> !txf_pop);

    // R11: interrupt only right after a pop
    a_r11_irq_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> $past(txf_pop));

    // R12: last word still shifting when the drain interrupt fires
    a_r12_irq_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> busy);

    // R13: at most one push per word
    a_r13_single_push: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_push |=> !rxf_push);

endmodule

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, cfg_wr = 1'b0;
    logic [15:0] cfg_brt = '0;
    logic [4:0]  cfg_wlen_m1 = 5'd7;
    logic        cfg_sclk_hi = 1'b0, cfg_lead_smp = 1'b1, cfg_msb_first = 1'b1, cfg_loopback = 1'b0;
    logic        tx_off = 1'b0, rx_off = 1'b0;
    logic        txf_empty = 1'b1;
    logic [31:0] txf_data = '0;
    logic        txf_pop, rxf_push, sclk, mosi, busy, tx_irq;
    logic        miso = 1'b0;
    logic [31:0] rxf_data;

    always #5 clk = ~clk;

    spi_shift_engine dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr), .cfg_brt(cfg_brt),
        .cfg_wlen_m1(cfg_wlen_m1), .cfg_sclk_hi(cfg_sclk_hi), .cfg_lead_smp(cfg_lead_smp),
        .cfg_msb_first(cfg_msb_first), .cfg_loopback(cfg_loopback),
        .tx_off(tx_off), .rx_off(rx_off), .txf_empty(txf_empty), .txf_data(txf_data),
        .txf_pop(txf_pop), .rxf_push(rxf_push), .rxf_data(rxf_data),
        .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy), .tx_irq(tx_irq)
    );

    int total = 0, bad = 0;
    int cyc = 0;
    bit done = 0;

    // expected configuration
    int c_br = 0, c_n = 8;
    bit c_pol = 0, c_lsmp = 1, c_msb = 1, c_loop = 0, c_txoff = 0, c_rxoff = 0;

    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    int irq_cnt = 0, irq_nobusy = 0, pops = 0;

    // slave model
    bit          sl_on = 0;
    int          sl_bit = 0, sl_idx = 0, edge_n = 0;
    int          edge_t[2];
    logic [31:0] sl_words[8];
    logic [31:0] sl_cap[8];

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (rxf_push) rxq.push_back(rxf_data);
        if (tx_irq) begin
            irq_cnt++;
            if (!busy) irq_nobusy++;
        end
        if (txf_pop) begin
            pops++;
            if (txq.size() > 0) void'(txq.pop_front());
        end
    end

    always @(negedge clk) begin
        txf_empty = (txq.size() == 0);
        txf_data  = (txq.size() > 0) ? txq[0] : 32'h0;
    end

    function automatic int bp(input int i);
        return c_msb ? (c_n - 1 - i) : i;
    endfunction

    function automatic logic [31:0] msk(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    function automatic logic [31:0] exp_mosi(input logic [31:0] tw);
        return c_txoff ? (c_pol ? msk(c_n) : 32'h0) : (tw & msk(c_n));
    endfunction

    function automatic logic [31:0] exp_rx(input logic [31:0] tw, input logic [31:0] sw);
        return c_loop ? exp_mosi(tw) : (sw & msk(c_n));
    endfunction

    task automatic sl_present();
        miso = sl_words[sl_idx][bp(sl_bit)];
    endtask

    always @(sclk) begin
        if (sl_on) begin
            automatic bit lead = (sclk !== c_pol);
            if (lead && edge_n < 2) begin
                edge_t[edge_n] = cyc;
                edge_n++;
            end
            if (lead == c_lsmp) sl_cap[sl_idx][bp(sl_bit)] = mosi;
            if (!lead) begin
                sl_bit++;
                if (sl_bit == c_n) begin
                    sl_bit = 0;
                    sl_idx++;
                end
                sl_present();
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic write_cfg(input int br, input int n, input bit pol, input bit lsmp,
                             input bit msb, input bit lp);
        @(negedge clk);
        cfg_brt = 16'(br); cfg_wlen_m1 = 5'(n - 1); cfg_sclk_hi = pol;
        cfg_lead_smp = lsmp; cfg_msb_first = msb; cfg_loopback = lp;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_cfg(input int br, input int n, input bit pol, input bit lsmp,
                           input bit msb, input bit lp);
        write_cfg(br, n, pol, lsmp, msb, lp);
        c_br = br; c_n = n; c_pol = pol; c_lsmp = lsmp; c_msb = msb; c_loop = lp;
    endtask

    task automatic burst(input int nw, input string tag);
        logic [31:0] tw[8];
        for (int i = 0; i < 8; i++) begin
            tw[i] = $urandom;
            sl_words[i] = $urandom;
            sl_cap[i] = '0;
        end
        rxq.delete();
        irq_cnt = 0; irq_nobusy = 0; pops = 0; edge_n = 0;
        sl_bit = 0; sl_idx = 0;
        @(negedge clk);
        tx_off = c_txoff; rx_off = c_rxoff;
        sl_present();
        sl_on = 1;
        for (int i = 0; i < nw; i++) txq.push_back(tw[i]);
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        for (int t = 0; t < 20000; t++) begin
            @(negedge clk);
            if (txq.size() == 0 && !busy) break;
        end
        repeat (3) @(negedge clk);
        en = 1'b0;
        sl_on = 0;
        // R13 R9: words delivered
        chk(rxq.size() == (c_rxoff ? 0 : nw), {tag, " R13/R9 rx count"}, rxq.size(), c_rxoff ? 0 : nw);
        chk(pops == nw, {tag, " R8 pops"}, pops, nw);
        if (!c_rxoff) begin
            for (int i = 0; i < nw && i < rxq.size(); i++)
                chk(rxq[i] === exp_rx(tw[i], sl_words[i]), {tag, " R4/R5/R6 rx word"},
                    rxq[i], exp_rx(tw[i], sl_words[i]));
        end
        for (int i = 0; i < nw; i++)
            chk((sl_cap[i] & msk(c_n)) === exp_mosi(tw[i]), {tag, " R4/R5/R8 mosi word"},
                sl_cap[i] & msk(c_n), exp_mosi(tw[i]));
        chk(irq_cnt == 1, {tag, " R11 irq count"}, irq_cnt, 1);
        chk(irq_nobusy == 0, {tag, " R12 busy at irq"}, irq_nobusy, 0);
        chk(edge_n == 2 && (edge_t[1] - edge_t[0]) == 2 * (c_br + 1), {tag, " R1 sclk period"},
            edge_t[1] - edge_t[0], 2 * (c_br + 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%h exp=%h", 1, 0);
        finish_up();
    end

    initial begin
        int lens[9] = '{2, 3, 4, 5, 6, 7, 8, 16, 32};
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        chk({sclk, mosi, busy, txf_pop, rxf_push, tx_irq} == 6'b0, "R14 reset outputs",
            {sclk, mosi, busy, txf_pop, rxf_push, tx_irq}, 0);

        // R14 default config: 8-bit, MSB first, lead sampling, brt 0
        burst(2, "R14 default");

        // directed: loopback, both phases, LSB first, 32 bits
        set_cfg(1, 32, 0, 0, 0, 1);
        burst(2, "R6 loop32");
        set_cfg(0, 16, 1, 1, 1, 0);
        burst(3, "R4 mode2");

        // R3 idle levels follow the rest-level field
        set_cfg(2, 5, 1, 0, 1, 0);
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1 && mosi == 1'b1, "R3 idle high", {sclk, mosi}, 2'b11);
        burst(2, "R3 idle high");

        // R7: write while enabled is ignored
        @(negedge clk); en = 1'b1;
        write_cfg(3, 16, 0, 1, 0, 1);
        @(negedge clk); en = 1'b0;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R7 locked rest level", sclk, 1);
        burst(2, "R7 locked");

        // R2: unsupported length keeps previous one, other fields update
        write_cfg(1, 11, 0, 1, 1, 0);
        c_br = 1; c_pol = 0; c_lsmp = 1; c_msb = 1; c_loop = 0;
        burst(2, "R2 bad length");

        // R8 transmitter off with loopback, R9 receiver off
        set_cfg(0, 8, 1, 1, 0, 1);
        c_txoff = 1; c_rxoff = 0;
        burst(2, "R8 txoff");
        set_cfg(1, 7, 0, 0, 1, 0);
        c_txoff = 0; c_rxoff = 1;
        burst(2, "R9 rxoff");

        // R10 both off
        @(negedge clk);
        tx_off = 1'b1; rx_off = 1'b1;
        txq.push_back(32'hA5A5_A5A5);
        txq.push_back(32'h5A5A_5A5A);
        @(negedge clk); en = 1'b1;
        repeat (40) @(negedge clk);
        chk(txq.size() == 2, "R10 no pop", txq.size(), 2);
        chk(busy == 1'b0 && sclk == c_pol, "R10 idle", {busy, sclk}, {1'b0, c_pol});
        en = 1'b0;
        @(negedge clk);
        txq.delete();
        @(negedge clk);

        // constrained random
        for (int it = 0; it < 14; it++) begin
            set_cfg($urandom % 4, lens[$urandom % 9], 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom));
            c_txoff = ($urandom % 4 == 0);
            c_rxoff = !c_txoff && ($urandom % 4 == 0);
            burst(1 + ($urandom % 5), "random");
        end
        finish_up();
    end

endmodule